// File: doc/BRIEF.md
# Software standby power-mode controller

This controller decides when a processor enters and leaves its deep standby state. A sleep strobe from the CPU takes the part into standby only while the standby-select control bit is set. With the bit clear, the strobe is an ordinary sleep and the controller leaves the clocks running. In standby the oscillator, the CPU clock and the peripheral clocks are all off, and the peripherals are held in reset. Register, RAM and port contents are kept, because nothing here clears them.

An enabled interrupt request that the CPU does not mask, or any NMI, wakes the part. The oscillator restarts at once, but the clocks come back only after a settling count. A 3-bit field selects that count from the table 2^(BASE_LOG2+field) oscillator cycles. Interrupt handling is then requested. When the reset pin goes low, the clocks return at once, with no settling count. Reset handling is requested when the pin goes high again. A low hardware-standby pin overrides everything else and parks the part until a reset.

A one-cycle exit pulse with a cause code marks each departure from standby. This makes the exit cause and the exact wake latency observable. The controller runs on the oscillator clock.

Top module: `sstby_ctrl`

## Requirements
- R1: A sleep strobe with the standby-select bit at 0 leaves the controller running: oscillator enable and clock enable stay 1 and peripheral reset stays 0.
- R2: A sleep strobe with the standby-select bit at 1 gives, from the next cycle on, oscillator enable 0, clock enable 0 and peripheral reset 1. These values hold until a wake event.
- R3: An NMI request wakes the part from standby regardless of the IRQ enables and the CPU mask. Its exit cause is 3.
- R4: An IRQ line n (n = 0, 1, 2) whose enable bit is 1 wakes the part while the CPU mask is 0. Its exit cause is 4+n, and the lower index wins when several lines are pending.
- R5: On an interrupt wake sampled at clock edge e, the oscillator enable is 1 from edge e. Clock enable rises at edge e+2^(BASE_LOG2+field). A one-cycle interrupt request pulse comes with it.
- R6: An IRQ request whose enable bit is 0, or that arrives while the CPU mask is 1, leaves the part in standby.
- R7: With the reset pin low, oscillator enable and clock enable are 1 and peripheral reset is 1 from the next cycle. A standby exit taken this way has cause 2, also while settling is in progress. One cycle after the pin returns high, a one-cycle reset request pulse appears and peripheral reset drops to 0.
- R8: With the hardware-standby pin low, from the next cycle oscillator enable and clock enable are 0 and peripheral reset is 1. A standby exit taken this way has cause 1. The state persists after the pin returns high, until the reset pin goes low.
- R9: When several exit events occur in the same cycle, priority is hardware standby (cause 1), then reset (2), then NMI (3), then the IRQs.
- R10: The exit pulse lasts exactly one cycle. It fires once per standby period and never on a reset or hardware-standby entry from the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| res_ni | input | 1 | Reset pin, active low, sampled synchronously |
| hstby_ni | input | 1 | Hardware-standby pin, active low |
| sleep_i | input | 1 | One-cycle strobe from the sleep instruction |
| ssby_i | input | 1 | Standby-select control bit |
| sts_i | input | STS_W | Settling-count selector |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| irq_en_i | input | NUM_IRQ | Per-line interrupt enables |
| cpu_mask_i | input | 1 | CPU interrupt mask, 1 blocks all IRQ lines |
| osc_en_o | output | 1 | Oscillator enable |
| clk_en_o | output | 1 | CPU and peripheral clock enable |
| periph_rst_o | output | 1 | On-chip peripheral reset |
| irq_req_o | output | 1 | One-cycle request for interrupt exception handling |
| rst_req_o | output | 1 | One-cycle request for reset exception handling |
| exit_o | output | 1 | One-cycle pulse on leaving standby |
| exit_cause_o | output | CAUSE_W | Cause of the last exit: 1 hw standby, 2 reset, 3 NMI, 4+n IRQ n |

## Verification
Two functions can fall in the same cycle: the settling countdown of an interrupt wake, and a reset or hardware-standby pin event. The reset or pin event either lands while the countdown is running or arrives on the same edge as the wake request. The bench provokes this by driving the reset or hardware-standby pin on the same negative edge as an NMI or IRQ request, or a few cycles into a long settling count. It judges the result by a single exit pulse carrying the higher-priority cause, with clock enable following the reset rule and not the count. It also sweeps every settling code against every interrupt source, and every enable and mask combination, comparing the latency with 2^(BASE_LOG2+code)+1 sampling cycles.

// File: rtl/sstby_pkg.sv
package sstby_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STBY   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_RSTH   = 3'd3,
        ST_HWSTBY = 3'd4
    } pm_state_e;

    localparam int unsigned CAUSE_NONE = 0;
    localparam int unsigned CAUSE_HW   = 1;
    localparam int unsigned CAUSE_RST  = 2;
    localparam int unsigned CAUSE_NMI  = 3;
    localparam int unsigned CAUSE_IRQ0 = 4;

endpackage

// File: rtl/sstby_wake_arb.sv
module sstby_wake_arb #(
    parameter int unsigned NUM_IRQ = 3,
    parameter int unsigned CAUSE_W = 3
) (
    input  logic               nmi_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               cpu_mask_i,
    output logic               wake_o,
    output logic [CAUSE_W-1:0] cause_o
);
    import sstby_pkg::*;

    logic [NUM_IRQ-1:0] live;

    assign live = irq_i & irq_en_i & {NUM_IRQ{~cpu_mask_i}};

    // NMI first, then lowest IRQ index
    always_comb begin
        wake_o  = nmi_i;
        cause_o = CAUSE_W'(CAUSE_NMI);
        if (!nmi_i) begin
            for (int i = NUM_IRQ - 1; i >= 0; i--) begin
                if (live[i]) begin
                    wake_o  = 1'b1;
                    cause_o = CAUSE_W'(CAUSE_IRQ0 + i);
                end
            end
        end
    end

    // masked or disabled IRQs never wake (R6)
    always_comb begin
        p_mask_blocks_r6: assert (nmi_i || !cpu_mask_i || !wake_o);
        p_disabled_blocks_r6: assert (nmi_i || ((irq_i & irq_en_i) != '0) || !wake_o);
    end

endmodule

// File: rtl/sstby_settle_timer.sv
module sstby_settle_timer #(
    parameter int unsigned BASE_LOG2 = 13,
    parameter int unsigned STS_W     = 3
) (
    input  logic             clk_i,
    input  logic             res_ni,
    input  logic             load_i,
    input  logic [STS_W-1:0] sts_i,
    output logic             done_o
);
    localparam int unsigned MAX_LOG2 = BASE_LOG2 + (1 << STS_W) - 1;
    localparam int unsigned CNT_W    = MAX_LOG2;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] len_m1;

    // 2^(BASE_LOG2+sts) - 1 as a right-shifted all-ones word
    assign len_m1 = {CNT_W{1'b1}} >> (CNT_W'(MAX_LOG2) - (CNT_W'(BASE_LOG2) + CNT_W'(sts_i)));

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_m1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!res_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // a freshly loaded count is never already expired (R5)
    p_load_not_done_r5: assert property (@(posedge clk_i) disable iff (!res_ni)
        load_i |=> !done_o);
    // the count moves down by one each cycle (R5)
    p_count_down_r5: assert property (@(posedge clk_i) disable iff (!res_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sstby_ctrl.sv
module sstby_ctrl #(
    parameter int unsigned NUM_IRQ   = 3,
    parameter int unsigned STS_W     = 3,
    parameter int unsigned BASE_LOG2 = 13,
    localparam int unsigned CAUSE_W  = $clog2(sstby_pkg::CAUSE_IRQ0 + NUM_IRQ)
) (
    input  logic               clk_i,
    input  logic               res_ni,
    input  logic               hstby_ni,
    input  logic               sleep_i,
    input  logic               ssby_i,
    input  logic [STS_W-1:0]   sts_i,
    input  logic               nmi_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               cpu_mask_i,
    output logic               osc_en_o,
    output logic               clk_en_o,
    output logic               periph_rst_o,
    output logic               irq_req_o,
    output logic               rst_req_o,
    output logic               exit_o,
    output logic [CAUSE_W-1:0] exit_cause_o
);
    import sstby_pkg::*;

    typedef struct packed {
        pm_state_e          state;
        logic               osc_en;
        logic               clk_en;
        logic               prst;
        logic               irq_req;
        logic               rst_req;
        logic               exit_p;
        logic [CAUSE_W-1:0] cause;
    } ctrl_t;

    ctrl_t              ctl_d, ctl_q;
    pm_state_e          nxt;
    logic               wake;
    logic [CAUSE_W-1:0] wake_cause;
    logic               settle_done;
    logic               load;
    logic               in_stby;

    sstby_wake_arb #(
        .NUM_IRQ (NUM_IRQ),
        .CAUSE_W (CAUSE_W)
    ) arb_i (
        .nmi_i      (nmi_i),
        .irq_i      (irq_i),
        .irq_en_i   (irq_en_i),
        .cpu_mask_i (cpu_mask_i),
        .wake_o     (wake),
        .cause_o    (wake_cause)
    );

    sstby_settle_timer #(
        .BASE_LOG2 (BASE_LOG2),
        .STS_W     (STS_W)
    ) tmr_i (
        .clk_i  (clk_i),
        .res_ni (res_ni),
        .load_i (load),
        .sts_i  (sts_i),
        .done_o (settle_done)
    );

    assign in_stby = (ctl_q.state == ST_STBY) || (ctl_q.state == ST_SETTLE);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.irq_req = 1'b0;
        ctl_d.rst_req = 1'b0;
        ctl_d.exit_p  = 1'b0;
        load          = 1'b0;
        nxt           = ctl_q.state;

        if (!hstby_ni) begin
            nxt = ST_HWSTBY;
        end else if (!res_ni) begin
            nxt = ST_RSTH;
        end else begin
            unique case (ctl_q.state)
                ST_RUN: begin
                    if (sleep_i && ssby_i) begin
                        nxt = ST_STBY;
                    end
                end
                ST_STBY: begin
                    if (wake) begin
                        nxt         = ST_SETTLE;
                        load        = 1'b1;
                        ctl_d.cause = wake_cause;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        nxt           = ST_RUN;
                        ctl_d.irq_req = 1'b1;
                    end
                end
                ST_RSTH: begin
                    nxt           = ST_RUN;
                    ctl_d.rst_req = 1'b1;
                end
                ST_HWSTBY: begin
                    nxt = ST_HWSTBY;
                end
                default: begin
                    nxt = ST_RSTH;
                end
            endcase
        end

        if (in_stby && (nxt != ST_STBY) && (nxt != ST_SETTLE)) begin
            ctl_d.exit_p = 1'b1;
            if (nxt == ST_HWSTBY) begin
                ctl_d.cause = CAUSE_W'(CAUSE_HW);
            end else if (nxt == ST_RSTH) begin
                ctl_d.cause = CAUSE_W'(CAUSE_RST);
            end
        end else if (nxt == ST_RSTH && ctl_q.state != ST_RSTH) begin
            ctl_d.cause = CAUSE_W'(CAUSE_NONE);
        end

        ctl_d.state  = nxt;
        ctl_d.osc_en = (nxt != ST_STBY) && (nxt != ST_HWSTBY);
        ctl_d.clk_en = (nxt == ST_RUN) || (nxt == ST_RSTH);
        ctl_d.prst   = (nxt != ST_RUN);
    end

    always_ff @(posedge clk_i) begin
        ctl_q <= ctl_d;
    end

    assign osc_en_o     = ctl_q.osc_en;
    assign clk_en_o     = ctl_q.clk_en;
    assign periph_rst_o = ctl_q.prst;
    assign irq_req_o    = ctl_q.irq_req;
    assign rst_req_o    = ctl_q.rst_req;
    assign exit_o       = ctl_q.exit_p;
    assign exit_cause_o = ctl_q.cause;

    // assertion gate: off until the first edge has loaded the registers
    logic armed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        armed_q <= 1'b1;
    end

    // sleep without standby-select keeps clocks running (R1)
    p_plain_sleep_r1: assert property (@(posedge clk_i) disable iff (!armed_q)
        (ctl_q.state == ST_RUN && res_ni && hstby_ni && !(sleep_i && ssby_i)) |=> (clk_en_o && osc_en_o));
    // standby stops everything and holds peripherals in reset (R2)
    p_stby_off_r2: assert property (@(posedge clk_i) disable iff (!armed_q)
        (ctl_q.state == ST_STBY) |-> (!osc_en_o && !clk_en_o && periph_rst_o));
    // no wake source leaves the part in standby (R6)
    p_no_wake_r6: assert property (@(posedge clk_i) disable iff (!armed_q)
        (ctl_q.state == ST_STBY && res_ni && hstby_ni && !nmi_i
         && ((irq_i & irq_en_i & {NUM_IRQ{~cpu_mask_i}}) == '0)) |=> (ctl_q.state == ST_STBY));
    // settling keeps oscillator on but clocks off (R5)
    p_settle_osc_r5: assert property (@(posedge clk_i) disable iff (!armed_q)
        (ctl_q.state == ST_SETTLE) |-> (osc_en_o && !clk_en_o));
    // interrupt request only at the end of settling (R5)
    p_irq_after_settle_r5: assert property (@(posedge clk_i) disable iff (!armed_q)
        (ctl_q.state == ST_SETTLE && res_ni && hstby_ni && settle_done) |=> (irq_req_o && clk_en_o));
    // reset low restores clocks in the next cycle (R7)
    p_rst_fast_r7: assert property (@(posedge clk_i) disable iff (!armed_q)
        (!res_ni && hstby_ni) |=> (osc_en_o && clk_en_o && periph_rst_o));
    // hardware-standby pin wins over everything (R8, R9)
    p_hw_wins_r9: assert property (@(posedge clk_i) disable iff (!armed_q)
        (!hstby_ni) |=> (!osc_en_o && !clk_en_o && periph_rst_o));
    // exit pulse lasts one cycle (R10)
    p_exit_single_r10: assert property (@(posedge clk_i) disable iff (!armed_q)
        exit_o |=> !exit_o);
    // reset request lasts one cycle (R7)
    p_rstreq_single_r7: assert property (@(posedge clk_i) disable iff (!armed_q)
        rst_req_o |=> !rst_req_o);

endmodule

// File: tb/sstby_ctrl_tb_top.sv
module sstby_ctrl_tb_top;

    localparam int NIRQ  = 3;
    localparam int BASE  = 2;
    localparam int CW    = 3;

    logic            clk = 1'b0;
    logic            res_n = 1'b0;
    logic            hstby_n = 1'b1;
    logic            sleep = 1'b0;
    logic            ssby = 1'b0;
    logic [2:0]      sts = '0;
    logic            nmi = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic [NIRQ-1:0] irq_en = '0;
    logic            cmask = 1'b0;
    logic            osc_en, clk_en, prst, irq_req, rst_req, exit_p;
    logic [CW-1:0]   cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sstby_ctrl #(
        .NUM_IRQ   (NIRQ),
        .STS_W     (3),
        .BASE_LOG2 (BASE)
    ) dut_i (
        .clk_i        (clk),
        .res_ni       (res_n),
        .hstby_ni     (hstby_n),
        .sleep_i      (sleep),
        .ssby_i       (ssby),
        .sts_i        (sts),
        .nmi_i        (nmi),
        .irq_i        (irq),
        .irq_en_i     (irq_en),
        .cpu_mask_i   (cmask),
        .osc_en_o     (osc_en),
        .clk_en_o     (clk_en),
        .periph_rst_o (prst),
        .irq_req_o    (irq_req),
        .rst_req_o    (rst_req),
        .exit_o       (exit_p),
        .exit_cause_o (cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_stby();
        sleep = 1'b1;
        ssby  = 1'b1;
        tick();
        sleep = 1'b0;
    endtask

    task automatic do_reset();
        res_n = 1'b0;
        tick(2);
        res_n = 1'b1;
        tick(2);
    endtask

    // count sampling cycles until clocks return; collect exit info
    task automatic measure(output int n, output int c, output int pulses, output int irqp);
        n = 0; c = -1; pulses = 0; irqp = 0;
        do begin
            tick();
            n++;
            if (exit_p) begin
                pulses++;
                c = int'(cause);
            end
            if (irq_req) irqp = 1;
        end while (!clk_en && n < 2000);
    endtask

    initial begin
        int n, c, p, ip;
        tick(3);
        chk("R7 reset osc", int'(osc_en), 1);
        chk("R7 reset clk", int'(clk_en), 1);
        chk("R7 reset prst", int'(prst), 1);
        chk("R10 no exit in reset", int'(exit_p), 0);
        res_n = 1'b1;
        tick();
        chk("R7 rst_req pulse", int'(rst_req), 1);
        chk("R7 prst released", int'(prst), 0);
        tick();
        chk("R7 rst_req ends", int'(rst_req), 0);

        // R1 plain sleep
        sleep = 1'b1; ssby = 1'b0;
        tick();
        sleep = 1'b0;
        tick(3);
        chk("R1 clk stays", int'(clk_en), 1);
        chk("R1 osc stays", int'(osc_en), 1);
        chk("R1 prst stays", int'(prst), 0);

        // R2 standby entry
        go_stby();
        chk("R2 osc off", int'(osc_en), 0);
        chk("R2 clk off", int'(clk_en), 0);
        chk("R2 prst on", int'(prst), 1);
        tick(5);
        chk("R2 still off", int'(osc_en | clk_en), 0);
        do_reset();

        // R3 R4 R5 sweep over settle codes and sources
        irq_en = '1; cmask = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int src = 0; src < 4; src++) begin
                sts = 3'(s);
                go_stby();
                if (src == 0) nmi = 1'b1;
                else irq[src-1] = 1'b1;
                measure(n, c, p, ip);
                chk("R5 latency", n, (1 << (BASE + s)) + 1);
                chk(src == 0 ? "R3 nmi cause" : "R4 irq cause", c, src == 0 ? 3 : 3 + src);
                chk("R10 one exit pulse", p, 1);
                chk("R5 irq_req at clk", int'(irq_req), 1);
                tick();
                chk("R5 irq_req one cycle", int'(irq_req), 0);
                chk("R10 exit one cycle", int'(exit_p), 0);
                nmi = 1'b0; irq = '0;
                tick();
            end
        end

        // R3 NMI ignores enables and mask
        sts = 3'd0; irq_en = '0; cmask = 1'b1;
        go_stby();
        nmi = 1'b1;
        measure(n, c, p, ip);
        chk("R3 nmi under mask", c, 3);
        chk("R3 nmi latency", n, (1 << BASE) + 1);
        nmi = 1'b0;
        tick();

        // R6 enable and mask sweep
        for (int ln = 0; ln < NIRQ; ln++) begin
            for (int en = 0; en < 2; en++) begin
                for (int mk = 0; mk < 2; mk++) begin
                    if (en == 1 && mk == 0) continue;
                    irq_en = en ? NIRQ'(1 << ln) : '0;
                    cmask  = 1'(mk);
                    go_stby();
                    irq[ln] = 1'b1;
                    tick(8);
                    chk("R6 blocked irq osc", int'(osc_en), 0);
                    chk("R6 blocked irq clk", int'(clk_en), 0);
                    irq = '0;
                    do_reset();
                end
            end
        end
        cmask = 1'b0; irq_en = '1;

        // R7 reset wake
        go_stby();
        res_n = 1'b0;
        tick();
        chk("R7 wake clk", int'(clk_en), 1);
        chk("R7 wake osc", int'(osc_en), 1);
        chk("R7 wake prst", int'(prst), 1);
        chk("R7 wake exit", int'(exit_p), 1);
        chk("R7 wake cause", int'(cause), 2);
        tick();
        chk("R10 exit ends", int'(exit_p), 0);
        res_n = 1'b1;
        tick();
        chk("R7 rst_req after wake", int'(rst_req), 1);
        tick();

        // R8 hardware standby from standby
        go_stby();
        hstby_n = 1'b0;
        tick();
        chk("R8 hw osc", int'(osc_en), 0);
        chk("R8 hw clk", int'(clk_en), 0);
        chk("R8 hw prst", int'(prst), 1);
        chk("R8 hw exit", int'(exit_p), 1);
        chk("R8 hw cause", int'(cause), 1);
        hstby_n = 1'b1;
        nmi = 1'b1;
        tick(4);
        chk("R8 hw persists", int'(osc_en | clk_en), 0);
        nmi = 1'b0;
        res_n = 1'b0;
        tick();
        chk("R8 reset leaves hw", int'(clk_en), 1);
        chk("R10 no exit from hw", int'(exit_p), 0);
        res_n = 1'b1;
        tick(2);

        // R8 R10 hardware standby from running
        hstby_n = 1'b0;
        tick();
        chk("R8 hw from run", int'(osc_en), 0);
        chk("R10 no exit from run", int'(exit_p), 0);
        hstby_n = 1'b1;
        do_reset();

        // R9 simultaneous events
        go_stby();
        res_n = 1'b0; hstby_n = 1'b0;
        tick();
        chk("R9 hw over reset", int'(cause), 1);
        hstby_n = 1'b1;
        tick();
        res_n = 1'b1;
        tick(2);

        go_stby();
        res_n = 1'b0; nmi = 1'b1;
        tick();
        chk("R9 reset over nmi", int'(cause), 2);
        chk("R9 reset over nmi clk", int'(clk_en), 1);
        res_n = 1'b1; nmi = 1'b0;
        tick(2);

        sts = 3'd0;
        go_stby();
        nmi = 1'b1; irq = 3'b101;
        measure(n, c, p, ip);
        chk("R9 nmi over irq", c, 3);
        nmi = 1'b0; irq = '0;
        tick();

        go_stby();
        irq = 3'b101;
        measure(n, c, p, ip);
        chk("R4 irq0 over irq2", c, 4);
        irq = '0;
        tick();

        go_stby();
        irq = 3'b110;
        measure(n, c, p, ip);
        chk("R4 irq1 over irq2", c, 5);
        irq = '0;
        tick();

        // R7 R9 reset during settling
        sts = 3'd7;
        go_stby();
        nmi = 1'b1;
        tick(5);
        chk("R5 settling clk off", int'(clk_en), 0);
        chk("R10 no exit while settling", int'(exit_p), 0);
        res_n = 1'b0;
        tick();
        chk("R7 reset aborts settle clk", int'(clk_en), 1);
        chk("R7 reset aborts settle exit", int'(exit_p), 1);
        chk("R7 reset aborts settle cause", int'(cause), 2);
        tick();
        chk("R10 single exit after abort", int'(exit_p), 0);
        res_n = 1'b1; nmi = 1'b0;
        tick(2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule